// File: doc/BRIEF.md
# Reorder Buffer with Paced Squash Walk

This block is a circular in-order window for in-flight instructions. Each slot holds a sequence number, a PC, a next PC, a completed flag and a squashed flag. New instructions are written at the tail, and the oldest instruction leaves from the head once it has completed. The block reports occupancy as full, empty and a free-slot count. It also shows the sequence number, PC and next PC of the head, and the sequence number and PC of the newest entry.

A squash request names a sequence number. Every entry younger than that number must be discarded. The entries are not flushed in one cycle. A small controller walks backward from the newest entry and marks at most `SQW` entries per cycle. It keeps its walk position from one cycle to the next. While it walks, the tail pointer and the occupancy do not move. When the walk meets an entry that is equal to or older than the squash number, or runs out of entries, the tail is pulled back behind the last survivor and the killed entries are freed, all in that one cycle. A done flag is low for the whole walk. Sequence numbers are compared modulo 2^`SEQW`, so `SEQW` must exceed log2(`DEPTH`)+1. `DEPTH` must be a power of two.

The walk controller has two states. `WALK_IDLE` moves to `WALK_BUSY` when it accepts a squash request (transition *start*). `WALK_BUSY` stays put while entries remain to be examined (transition *step*). In `WALK_BUSY`, a new request carrying an older number replaces the squash number for that cycle and marks nothing (transition *retarget*). `WALK_BUSY` returns to `WALK_IDLE` in the cycle the walk ends (transition *finish*).

Top module: `rob_squash_top`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `free_cnt`=`DEPTH`, `sq_done`=1 and `commit_fire`=0.
- R2: `full` is 1 exactly when occupancy equals `DEPTH`. `empty` is 1 exactly when occupancy is 0. `free_cnt` equals `DEPTH` minus occupancy.
- R3: Inserts are accepted when `ins_valid`=1, the buffer is not full, no walk is active and `sq_valid`=0. An accepted insert lands at slot `alloc_idx`. From the next cycle it appears on `tail_seq`/`tail_pc`. If the buffer was empty, it also appears on `head_seq`/`head_pc`/`head_npc`. An insert while full is a protocol violation and is ignored.
- R4: `commit_fire` is 1 in a cycle where `commit_req`=1, the buffer is not empty, the head entry is completed and not squashed, no walk is active and `sq_valid`=0. The head then advances by one at the next edge.
- R5: An accepted insert and a commit in the same cycle leave occupancy unchanged.
- R6: An accepted squash drives `sq_done` low from the next cycle. `sq_done` stays low for one cycle per group of `SQW` entries examined. The walk ends in the cycle it meets an entry that is not younger, or runs out of entries. An empty buffer takes one cycle.
- R7: When the walk finishes, `tail_seq` shows the newest surviving entry and `free_cnt` grows by the number of killed entries. If no entry survives, `empty` becomes 1. While the walk runs, `tail_seq` and `free_cnt` hold their values.
- R8: While `sq_done`=0, inserts and commits are not accepted and leave no trace.
- R9: Entry A is younger than squash number S when (A−S) mod 2^`SEQW` is nonzero and below 2^(`SEQW`−1). This holds across wrap of the sequence counter.
- R10: During a walk, a request whose number is older than the active one replaces it, and the walk continues from its current position. A request whose number is equal or younger is ignored.
- R11: `cpl_valid` sets the completed flag of slot `cpl_idx`. A head that is not completed is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQW | Sequence number of the new entry |
| ins_pc | input | PCW | PC of the new entry |
| ins_npc | input | PCW | Next PC of the new entry |
| alloc_idx | output | log2(DEPTH) | Slot the next insert will occupy |
| cpl_valid | input | 1 | Mark a slot completed |
| cpl_idx | input | log2(DEPTH) | Slot to mark completed |
| commit_req | input | 1 | Request to retire the head |
| commit_fire | output | 1 | Head retires at this edge |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQW | Squash sequence number |
| sq_done | output | 1 | No walk in progress |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| free_cnt | output | log2(DEPTH+1) | Free slots |
| head_seq | output | SEQW | Head sequence number (undefined when empty) |
| head_pc | output | PCW | Head PC (undefined when empty) |
| head_npc | output | PCW | Head next PC (undefined when empty) |
| tail_seq | output | SEQW | Newest entry sequence number (undefined when empty) |
| tail_pc | output | PCW | Newest entry PC (undefined when empty) |

## Verification
The squash walk is run from a vector table covering these cases:
- an older entry found partway through a group of `SQW` entries,
- an older entry found at a group boundary,
- every entry younger, with the buffer full,
- no entry younger,
- an empty buffer,
- squash numbers and entry numbers that straddle the sequence wrap.

The walk length tells whether marking is paced per cycle. The final free count and tail value tell whether the stop point is right. The wrap cases show whether the comparison is modular rather than plain unsigned. Directed runs cover the remaining behaviour:
- a walk retargeted by an older number, against one given a younger number;
- inserts and commits held off during a walk;
- an insert and a commit in the same cycle;
- an insert while full;
- a commit blocked by a head that has not completed.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [0:0] {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;
endpackage

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
    parameter int DEPTH = 8,
    parameter int SEQW  = 8,
    parameter int PCW   = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [SEQW-1:0] wr_seq,
    input  logic [PCW-1:0]  wr_pc,
    input  logic [PCW-1:0]  wr_npc,
    input  logic            cpl_en,
    input  logic [IW-1:0]   cpl_idx,
    input  logic [DEPTH-1:0] mark_vec,
    input  logic [IW-1:0]   head_idx,
    input  logic [IW-1:0]   last_idx,
    output logic [SEQW-1:0] seq_all [DEPTH],
    output logic [SEQW-1:0] head_seq,
    output logic [PCW-1:0]  head_pc,
    output logic [PCW-1:0]  head_npc,
    output logic            head_done,
    output logic            head_sqd,
    output logic [SEQW-1:0] last_seq,
    output logic [PCW-1:0]  last_pc
);
    logic [SEQW-1:0]  seq_q [DEPTH];
    logic [PCW-1:0]   pc_q  [DEPTH];
    logic [PCW-1:0]   npc_q [DEPTH];
    logic [DEPTH-1:0] done_q;
    logic [DEPTH-1:0] sqd_q;

    // payload: no reset needed, validity comes from the pointers
    always_ff @(posedge clk) begin
        if (wr_en) begin
            seq_q[wr_idx] <= wr_seq;
            pc_q[wr_idx]  <= wr_pc;
            npc_q[wr_idx] <= wr_npc;
        end
    end

    // per-slot status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
            sqd_q  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_idx == IW'(i)) begin
                    done_q[i] <= 1'b0;
                    sqd_q[i]  <= 1'b0;
                end else begin
                    if (cpl_en && cpl_idx == IW'(i)) done_q[i] <= 1'b1;
                    if (mark_vec[i])                 sqd_q[i]  <= 1'b1;
                end
            end
        end
    end

    assign seq_all   = seq_q;
    assign head_seq  = seq_q[head_idx];
    assign head_pc   = pc_q[head_idx];
    assign head_npc  = npc_q[head_idx];
    assign head_done = done_q[head_idx];
    assign head_sqd  = sqd_q[head_idx];
    assign last_seq  = seq_q[last_idx];
    assign last_pc   = pc_q[last_idx];
endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SQW   = 2,
    parameter int SEQW  = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEQW-1:0]  req_seq,
    input  logic [IW-1:0]    tail_idx,
    input  logic [CW-1:0]    occ,
    input  logic [SEQW-1:0]  seq_all [DEPTH],
    output logic             busy,
    output logic [DEPTH-1:0] mark_vec,
    output logic             fin,
    output logic [IW-1:0]    fin_tail,
    output logic [CW-1:0]    fin_kill
);
    walk_state_e     state_q;
    logic [IW-1:0]   wptr_q;
    logic [CW-1:0]   left_q;
    logic [CW-1:0]   nkill_q;
    logic [SEQW-1:0] wseq_q;

    logic            retarget;
    logic [CW-1:0]   nstep;

    // a is younger than b under modular ordering
    function automatic logic is_younger(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
        logic [SEQW-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQW-1];
    endfunction

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            wptr_q  <= '0;
            left_q  <= '0;
            nkill_q <= '0;
            wseq_q  <= '0;
        end else begin
            unique case (state_q)
                WALK_IDLE: begin
                    if (req_valid) begin          // start
                        state_q <= WALK_BUSY;
                        wptr_q  <= tail_idx - IW'(1);
                        left_q  <= occ;
                        nkill_q <= '0;
                        wseq_q  <= req_seq;
                    end
                end
                WALK_BUSY: begin
                    if (fin) begin                // finish
                        state_q <= WALK_IDLE;
                    end else if (retarget) begin  // retarget
                        wseq_q  <= req_seq;
                    end else begin                // step
                        wptr_q  <= wptr_q - IW'(nstep);
                        left_q  <= left_q - nstep;
                        nkill_q <= nkill_q + nstep;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        logic go;
        logic hit_old;
        logic [IW-1:0] idx;
        busy     = (state_q == WALK_BUSY);
        retarget = busy && req_valid && is_younger(wseq_q, req_seq);
        go       = busy && !retarget;
        hit_old  = 1'b0;
        nstep    = '0;
        mark_vec = '0;
        for (int k = 0; k < SQW; k++) begin
            idx = wptr_q - IW'(k);
            if (go) begin
                if (left_q > CW'(k)) begin
                    if (is_younger(seq_all[idx], wseq_q)) begin
                        mark_vec[idx] = 1'b1;
                        nstep         = nstep + CW'(1);
                    end else begin
                        hit_old = 1'b1;
                        go      = 1'b0;
                    end
                end else begin
                    go = 1'b0;
                end
            end
        end
        fin      = busy && !retarget && (hit_old || left_q == nstep);
        fin_tail = wptr_q - IW'(nstep) + IW'(1);
        fin_kill = nkill_q + nstep;
    end
endmodule

// File: rtl/rob_squash_top.sv
module rob_squash_top #(
    parameter int DEPTH = 8,
    parameter int SQW   = 2,
    parameter int SEQW  = 8,
    parameter int PCW   = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic [SEQW-1:0] ins_seq,
    input  logic [PCW-1:0]  ins_pc,
    input  logic [PCW-1:0]  ins_npc,
    output logic [IW-1:0]   alloc_idx,
    input  logic            cpl_valid,
    input  logic [IW-1:0]   cpl_idx,
    input  logic            commit_req,
    output logic            commit_fire,
    input  logic            sq_valid,
    input  logic [SEQW-1:0] sq_seq,
    output logic            sq_done,
    output logic            full,
    output logic            empty,
    output logic [CW-1:0]   free_cnt,
    output logic [SEQW-1:0] head_seq,
    output logic [PCW-1:0]  head_pc,
    output logic [PCW-1:0]  head_npc,
    output logic [SEQW-1:0] tail_seq,
    output logic [PCW-1:0]  tail_pc
);
    logic [IW-1:0]    head_q, tail_q;
    logic [CW-1:0]    occ_q;
    logic             busy, fin, ins_fire, head_done, head_sqd, idle_ok;
    logic [DEPTH-1:0] mark_vec;
    logic [IW-1:0]    fin_tail;
    logic [CW-1:0]    fin_kill;
    logic [SEQW-1:0]  seq_all [DEPTH];

    assign idle_ok     = !busy && !sq_valid;
    assign ins_fire    = ins_valid && !full && idle_ok;
    assign commit_fire = commit_req && !empty && head_done && !head_sqd && idle_ok;
    assign full        = (occ_q == CW'(DEPTH));
    assign empty       = (occ_q == '0);
    assign free_cnt    = CW'(DEPTH) - occ_q;
    assign sq_done     = !busy;
    assign alloc_idx   = tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else if (fin) begin
            tail_q <= fin_tail;
            occ_q  <= occ_q - fin_kill;
        end else begin
            if (ins_fire)    tail_q <= tail_q + IW'(1);
            if (commit_fire) head_q <= head_q + IW'(1);
            occ_q <= occ_q + CW'(ins_fire) - CW'(commit_fire);
        end
    end

    rob_entry_array #(.DEPTH(DEPTH), .SEQW(SEQW), .PCW(PCW)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ins_fire), .wr_idx(tail_q), .wr_seq(ins_seq), .wr_pc(ins_pc), .wr_npc(ins_npc),
        .cpl_en(cpl_valid), .cpl_idx(cpl_idx), .mark_vec(mark_vec),
        .head_idx(head_q), .last_idx(tail_q - IW'(1)),
        .seq_all(seq_all), .head_seq(head_seq), .head_pc(head_pc), .head_npc(head_npc),
        .head_done(head_done), .head_sqd(head_sqd), .last_seq(tail_seq), .last_pc(tail_pc)
    );

    rob_squash_walk #(.DEPTH(DEPTH), .SQW(SQW), .SEQW(SEQW)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(sq_valid), .req_seq(sq_seq), .tail_idx(tail_q), .occ(occ_q),
        .seq_all(seq_all), .busy(busy), .mark_vec(mark_vec),
        .fin(fin), .fin_tail(fin_tail), .fin_kill(fin_kill)
    );
endmodule

// File: rtl/rob_squash_chk.sv
module rob_squash_chk #(
    parameter int DEPTH = 8,
    parameter int SEQW  = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sq_valid,
    input logic            sq_done,
    input logic            full,
    input logic            empty,
    input logic [CW-1:0]   free_cnt,
    input logic [SEQW-1:0] tail_seq,
    input logic            commit_fire
);
    a_r2_full_free: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (free_cnt == '0) && !empty);
    a_r2_empty_free: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (free_cnt == CW'(DEPTH)));
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        full && !commit_fire && sq_done && !sq_valid |=> full);
    a_r4_commit_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        commit_fire |-> !empty);
    a_r6_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        sq_done && sq_valid |=> !sq_done);
    a_r7_free_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_done |=> (sq_done || $stable(free_cnt)));
    a_r7_tail_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_done && !empty |=> (sq_done || $stable(tail_seq)));
    a_r8_no_commit_walk: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_done |-> !commit_fire);
endmodule

bind rob_squash_top rob_squash_chk #(.DEPTH(DEPTH), .SEQW(SEQW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_done(sq_done),
    .full(full), .empty(empty), .free_cnt(free_cnt), .tail_seq(tail_seq),
    .commit_fire(commit_fire)
);

// File: tb/sim_rob_squash_top.sv
`timescale 1ns/1ps
module sim_rob_squash_top;
    localparam int DEPTH = 8;
    localparam int SQW   = 2;
    localparam int SEQW  = 8;
    localparam int PCW   = 32;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    // {fill, base, squash seq, killed, walk cycles, tail after}
    localparam logic [47:0] VECS [8] = '{
        48'h050A0C02020C, 48'h050A0D01010D, 48'h081413080400, 48'h06FCFD0403FD,
        48'h03282A00012A, 48'h076464060464, 48'h000005000100, 48'h0300FF030200
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0, cpl_valid = 1'b0, commit_req = 1'b0, sq_valid = 1'b0;
    logic [SEQW-1:0] ins_seq = '0, sq_seq = '0;
    logic [PCW-1:0]  ins_pc = '0, ins_npc = '0;
    logic [IW-1:0]   cpl_idx = '0, alloc_idx;
    logic commit_fire, sq_done, full, empty;
    logic [CW-1:0]   free_cnt;
    logic [SEQW-1:0] head_seq, tail_seq;
    logic [PCW-1:0]  head_pc, head_npc, tail_pc;

    int errs = 0, checks = 0, cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rob_squash_top #(.DEPTH(DEPTH), .SQW(SQW), .SEQW(SEQW), .PCW(PCW)) u0 (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
        .ins_pc(ins_pc), .ins_npc(ins_npc), .alloc_idx(alloc_idx),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .commit_req(commit_req),
        .commit_fire(commit_fire), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .sq_done(sq_done), .full(full), .empty(empty), .free_cnt(free_cnt),
        .head_seq(head_seq), .head_pc(head_pc), .head_npc(head_npc),
        .tail_seq(tail_seq), .tail_pc(tail_pc)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [PCW-1:0] pc_of(input logic [SEQW-1:0] s);
        return 32'h1000 + {22'd0, s, 2'b00};
    endfunction

    task automatic push(input logic [SEQW-1:0] s);
        if (full) $display("note: protocol violation flagged, insert of %0d while full", s);
        ins_valid = 1'b1; ins_seq = s; ins_pc = pc_of(s); ins_npc = pc_of(s) + 4;
        @(negedge clk) ins_valid = 1'b0;
    endtask

    task automatic complete(input logic [IW-1:0] idx);
        cpl_valid = 1'b1; cpl_idx = idx;
        @(negedge clk) cpl_valid = 1'b0;
    endtask

    // squash with s1; optionally a second request s2 in the first walk cycle
    task automatic squash(input logic [SEQW-1:0] s1, input bit two,
                          input logic [SEQW-1:0] s2, output int n);
        n = 0;
        sq_valid = 1'b1; sq_seq = s1;
        @(negedge clk);
        if (two) begin
            sq_seq = s2;
            n = 1;
            @(negedge clk);
        end
        sq_valid = 1'b0;
        while (!sq_done && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] fill, base, sq, kill, wc, tl;
        do_reset();
        // R1 reset state
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 free_cnt", free_cnt, DEPTH);
        chk("R1 sq_done", sq_done, 1);
        chk("R1 commit_fire", commit_fire, 0);

        // table-driven squash walks: R6 R7 R9
        for (int v = 0; v < 8; v++) begin
            {fill, base, sq, kill, wc, tl} = VECS[v];
            do_reset();
            for (int i = 0; i < int'(fill); i++) push(base + 8'(i));
            squash(sq, 1'b0, 8'd0, n);
            chk($sformatf("R6 walk cycles vec%0d", v), n, wc);
            chk($sformatf("R7 free_cnt vec%0d (R9 ordering)", v), free_cnt, DEPTH - fill + kill);
            if (fill != kill) chk($sformatf("R7 tail_seq vec%0d", v), tail_seq, tl);
            else              chk($sformatf("R7 empty vec%0d", v), empty, 1);
        end

        // fill, full, insert while full
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(8'(i));
        chk("R2 full", full, 1);
        chk("R2 free_cnt", free_cnt, 0);
        chk("R2 empty", empty, 0);
        push(8'd99);
        chk("R3 ignored insert tail_seq", tail_seq, 7);
        chk("R3 ignored insert free_cnt", free_cnt, 0);
        chk("R3 head_seq", head_seq, 0);
        chk("R3 head_pc", head_pc, pc_of(8'd0));
        chk("R3 head_npc", head_npc, pc_of(8'd0) + 4);
        chk("R3 tail_pc", tail_pc, pc_of(8'd7));

        // R11 commit waits for completion
        commit_req = 1'b1; #1;
        chk("R11 no commit before complete", commit_fire, 0);
        @(negedge clk) commit_req = 1'b0;
        chk("R11 head kept", head_seq, 0);
        complete(3'd0);
        commit_req = 1'b1; #1;
        chk("R4 commit_fire", commit_fire, 1);
        @(negedge clk) commit_req = 1'b0;
        chk("R4 head advanced", head_seq, 1);
        chk("R4 free_cnt", free_cnt, 1);

        // R5 insert and commit together
        complete(3'd1);
        commit_req = 1'b1;
        push(8'd8);
        commit_req = 1'b0;
        chk("R5 free_cnt net", free_cnt, 1);
        chk("R5 tail_seq", tail_seq, 8);
        chk("R5 head_seq", head_seq, 2);

        // R8 inserts and commits blocked during a walk
        complete(3'd2);
        sq_valid = 1'b1; sq_seq = 8'd2;
        @(negedge clk) sq_valid = 1'b0;
        ins_valid = 1'b1; ins_seq = 8'd50; ins_pc = pc_of(8'd50); ins_npc = pc_of(8'd50);
        commit_req = 1'b1;
        n = 0;
        while (!sq_done && n < 100) begin
            n++;
            @(negedge clk);
        end
        ins_valid = 1'b0; commit_req = 1'b0;
        chk("R6 walk cycles while blocked", n, 4);
        chk("R8 free_cnt after walk", free_cnt, 7);
        chk("R8 tail_seq after walk", tail_seq, 2);
        chk("R8 head_seq after walk", head_seq, 2);

        // R10 retarget with an older number
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(8'(60 + i));
        squash(8'd65, 1'b1, 8'd61, n);
        chk("R10 retarget cycles", n, 5);
        chk("R10 retarget free_cnt", free_cnt, 6);
        chk("R10 retarget tail_seq", tail_seq, 61);

        // R10 younger request ignored
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(8'(60 + i));
        squash(8'd62, 1'b1, 8'd66, n);
        chk("R10 ignored cycles", n, 3);
        chk("R10 ignored free_cnt", free_cnt, 5);
        chk("R10 ignored tail_seq", tail_seq, 62);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule